// File: doc/BRIEF.md
# Involuntary Counter Request Arbiter

This block sits beside a one's-complement datapath. It decides which memory-resident counter is bumped next. Every counter owns two request cells: an up cell and a down cell. External count pulses, a periodic timing tick, overflow of a neighbouring counter and overflow tests on the write bus can all set these cells. A fixed-priority encoder picks the pending counter with the lowest address. When the sequencer strobes "grab", the winner's index and direction are latched and presented as a 2-bit subsequence select. The sequencer then runs an increment or decrement step through the main datapath.

During that step the sequencer can ask the block to place the counter's memory address on the read bus. It then strobes "done" while the updated value sits on the write bus. The block inspects the two top write-bus bits for positive overflow. Overflow of the low clock word carries into the high clock word's up cell. Overflow of either general timer produces a one-cycle interrupt trigger.

An up request and a down request that are both pending on the same counter cancel each other inside the cell bank. Neither is ever selected, so no counter can be starved waiting for a completion strobe that never comes.

Top module: `ctr_prio_arbiter`

## Requirements
- R1: A synchronous active-high reset empties every request cell, forces `subseq` to 00 and drives both interrupt triggers low. After reset, a grab with no new requests selects nothing.
- R2: A one-cycle `tick` sets the up cells of the low clock word (address 036 octal), timer A (037 octal) and timer B (040 octal).
- R3: While `grab_n` is low at a clock edge, the pending counter with the lowest index (lowest address) is latched and its cell is consumed. `subseq` becomes 01 for an up request, 10 for a down request, and 00 when no cell is pending. Cell indices are 0 overflow counter, 1 high clock word, 2 low clock word, 3 timer A, 4 timer B.
- R4: While `show_n` is low and a counter is latched, `rbus` carries `ADDR_BASE` (034 octal) plus the latched index. Otherwise `rbus` is zero. `rbus_oe` is high exactly while `show_n` is low.
- R5: A clock edge with `done_n` low retires the latched selection, and `subseq` returns to 00.
- R6: When `done_n` is low, the latched counter is the low clock word and `wb_top` is 01 (positive overflow: bit 1 is sign, bit 0 is overflow), the high clock word's up cell is set.
- R7: Under the same overflow condition, timer A pulses `irq_tmra` high for exactly one cycle after the edge and timer B pulses `irq_tmrb`. No other counter and no other `wb_top` value pulses either output.
- R8: A clock edge with `ovchk_n` low sets the overflow counter's up cell when `wb_top` is 01 and its down cell when `wb_top` is 10. Values 00 and 11 change nothing.
- R9: Up and down requests that are both pending on one counter, whether they arrive together or one after the other, cancel. Both cells clear and a later grab selects nothing for that counter.
- R10: A request for the latched counter that arrives after its grab stays pending. It is not cancelled against the step in flight and is served by a later grab.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Periodic timing tick, one-cycle pulse |
| cnt_up | input | NCELL | Per-counter external up-count pulses |
| cnt_dn | input | NCELL | Per-counter external down-count pulses |
| grab_n | input | 1 | Latch winner and direction, active low |
| show_n | input | 1 | Drive latched counter address on read bus, active low |
| done_n | input | 1 | Retire selection and test overflow, active low |
| ovchk_n | input | 1 | Overflow test feeding the overflow counter, active low |
| wb_top | input | 2 | Write-bus sign (bit 1) and overflow (bit 0) bits |
| rbus | output | DW | Read-bus value |
| rbus_oe | output | 1 | Read-bus drive enable |
| subseq | output | 2 | Subsequence select: 00 none, 01 up, 10 down |
| irq_tmra | output | 1 | One-cycle trigger on timer A positive overflow |
| irq_tmrb | output | 1 | One-cycle trigger on timer B positive overflow |

## Verification
The assertions assume the sequencer never lowers `grab_n` and `done_n` in the same cycle. They also assume `done_n` is used only to close a step opened by a grab, so a retire is never followed by a second retire without a grab in between. The stimulus table and the directed sequences keep every strobe to a single cycle and always put a grab before the matching show and done. External count pulses may land in any cycle, including between a grab and its done, because the cell bank is required to absorb them.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_UP   = 2'b01,
    SEL_DN   = 2'b10
  } sel_e;

  // top two write-bus bits: {sign, overflow}
  function automatic logic ovf_pos(input logic [1:0] t);
    return t == 2'b01;
  endfunction

  function automatic logic ovf_neg(input logic [1:0] t);
    return t == 2'b10;
  endfunction

endpackage

// File: rtl/cpa_cell_bank.sv
module cpa_cell_bank #(
  parameter int NCELL = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] set_up,
  input  logic [NCELL-1:0] set_dn,
  input  logic [NCELL-1:0] take,
  output logic [NCELL-1:0] pend_up,
  output logic [NCELL-1:0] pend_dn
);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic up_q, dn_q, nxt_up, nxt_dn;

    always_comb begin
      nxt_up = (up_q & ~take[i]) | set_up[i];
      nxt_dn = (dn_q & ~take[i]) | set_dn[i];
    end

    // opposing requests annihilate inside the cell
    always_ff @(posedge clk) begin
      if (rst) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= nxt_up & ~nxt_dn;
        dn_q <= nxt_dn & ~nxt_up;
      end
    end

    assign pend_up[i] = up_q;
    assign pend_dn[i] = dn_q;
  end

endmodule

// File: rtl/cpa_prio_enc.sv
module cpa_prio_enc #(
  parameter int NCELL = 5,
  localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic [NCELL-1:0] req,
  output logic [NCELL-1:0] grant,
  output logic [IW-1:0]    idx,
  output logic             any
);

  // lowest index wins
  assign grant = req & (~req + NCELL'(1));
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = NCELL - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/cpa_ovf_route.sv
module cpa_ovf_route
  import cpa_pkg::*;
#(
  parameter int NCELL     = 5,
  parameter int IDX_OVC   = 0,
  parameter int IDX_RTCHI = 1,
  parameter int IDX_RTCLO = 2,
  parameter int IDX_TMRA  = 3,
  parameter int IDX_TMRB  = 4,
  localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             retire,
  input  logic             ovchk,
  input  logic             sel_valid,
  input  logic [IW-1:0]    sel_idx,
  input  logic [1:0]       wb_top,
  output logic [NCELL-1:0] int_up,
  output logic [NCELL-1:0] int_dn,
  output logic             irq_tmra,
  output logic             irq_tmrb
);

  logic carry;
  assign carry = retire & sel_valid & ovf_pos(wb_top);

  always_comb begin
    int_up = '0;
    int_dn = '0;
    if (tick) begin
      int_up[IDX_RTCLO] = 1'b1;
      int_up[IDX_TMRA]  = 1'b1;
      int_up[IDX_TMRB]  = 1'b1;
    end
    if (carry && sel_idx == IW'(IDX_RTCLO)) int_up[IDX_RTCHI] = 1'b1;
    if (ovchk && ovf_pos(wb_top)) int_up[IDX_OVC] = 1'b1;
    if (ovchk && ovf_neg(wb_top)) int_dn[IDX_OVC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tmra <= 1'b0;
      irq_tmrb <= 1'b0;
    end else begin
      irq_tmra <= carry && sel_idx == IW'(IDX_TMRA);
      irq_tmrb <= carry && sel_idx == IW'(IDX_TMRB);
    end
  end

endmodule

// File: rtl/ctr_prio_arbiter.sv
module ctr_prio_arbiter
  import cpa_pkg::*;
#(
  parameter int NCELL     = 5,
  parameter int DW        = 16,
  parameter int ADDR_BASE = 28,
  parameter int IDX_OVC   = 0,
  parameter int IDX_RTCHI = 1,
  parameter int IDX_RTCLO = 2,
  parameter int IDX_TMRA  = 3,
  parameter int IDX_TMRB  = 4,
  localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NCELL-1:0] cnt_up,
  input  logic [NCELL-1:0] cnt_dn,
  input  logic             grab_n,
  input  logic             show_n,
  input  logic             done_n,
  input  logic             ovchk_n,
  input  logic [1:0]       wb_top,
  output logic [DW-1:0]    rbus,
  output logic             rbus_oe,
  output logic [1:0]       subseq,
  output logic             irq_tmra,
  output logic             irq_tmrb
);

  logic [NCELL-1:0] pend_up, pend_dn, int_up, int_dn, grant, take;
  logic [IW-1:0]    win_idx, idx_q;
  logic             win_any, sel_valid;
  sel_e             sel_q;

  assign sel_valid = sel_q != SEL_NONE;
  assign take      = grab_n ? '0 : grant;

  cpa_ovf_route #(
    .NCELL(NCELL), .IDX_OVC(IDX_OVC), .IDX_RTCHI(IDX_RTCHI),
    .IDX_RTCLO(IDX_RTCLO), .IDX_TMRA(IDX_TMRA), .IDX_TMRB(IDX_TMRB)
  ) u_ovf (
    .clk(clk), .rst(rst), .tick(tick), .retire(~done_n), .ovchk(~ovchk_n),
    .sel_valid(sel_valid), .sel_idx(idx_q), .wb_top(wb_top),
    .int_up(int_up), .int_dn(int_dn),
    .irq_tmra(irq_tmra), .irq_tmrb(irq_tmrb)
  );

  cpa_cell_bank #(.NCELL(NCELL)) u_cells (
    .clk(clk), .rst(rst),
    .set_up(cnt_up | int_up), .set_dn(cnt_dn | int_dn), .take(take),
    .pend_up(pend_up), .pend_dn(pend_dn)
  );

  cpa_prio_enc #(.NCELL(NCELL)) u_enc (
    .req(pend_up | pend_dn), .grant(grant), .idx(win_idx), .any(win_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_NONE;
      idx_q <= '0;
    end else if (!grab_n) begin
      idx_q <= win_idx;
      if (!win_any)                sel_q <= SEL_NONE;
      else if (|(grant & pend_up)) sel_q <= SEL_UP;
      else                         sel_q <= SEL_DN;
    end else if (!done_n) begin
      sel_q <= SEL_NONE;
    end
  end

  assign subseq  = sel_q;
  assign rbus_oe = ~show_n;
  assign rbus    = (!show_n && sel_valid) ? DW'(ADDR_BASE) + DW'(idx_q) : '0;

endmodule

// File: rtl/cpa_checker.sv
module cpa_checker #(
  parameter int NCELL     = 5,
  parameter int DW        = 16,
  parameter int ADDR_BASE = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             grab_n,
  input logic             show_n,
  input logic             done_n,
  input logic [1:0]       subseq,
  input logic [DW-1:0]    rbus,
  input logic             irq_tmra,
  input logic             irq_tmrb,
  input logic [NCELL-1:0] pend_up,
  input logic [NCELL-1:0] pend_dn
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (subseq == 2'b00 && !irq_tmra && !irq_tmrb));

  a_r9_no_dual_pending: assert property (@(posedge clk) disable iff (rst)
    (pend_up & pend_dn) == '0);

  a_r3_select_holds: assert property (@(posedge clk) disable iff (rst)
    (grab_n && done_n) |=> $stable(subseq));

  a_r5_retire_clears: assert property (@(posedge clk) disable iff (rst)
    (!done_n && grab_n) |=> subseq == 2'b00);

  a_r7_irq_after_retire: assert property (@(posedge clk) disable iff (rst)
    (irq_tmra || irq_tmrb) |-> $past(!done_n));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    (irq_tmra || irq_tmrb) |=> !(irq_tmra || irq_tmrb));

  a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
    (!show_n && subseq != 2'b00) |->
      (rbus >= DW'(ADDR_BASE) && rbus < DW'(ADDR_BASE + NCELL)));

endmodule

bind ctr_prio_arbiter cpa_checker #(
  .NCELL(NCELL), .DW(DW), .ADDR_BASE(ADDR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .grab_n(grab_n), .show_n(show_n), .done_n(done_n),
  .subseq(subseq), .rbus(rbus), .irq_tmra(irq_tmra), .irq_tmrb(irq_tmrb),
  .pend_up(pend_up), .pend_dn(pend_dn)
);

// File: tb/sim_ctr_prio_arbiter.sv
module sim_ctr_prio_arbiter;

  localparam int NC = 5;
  localparam int BASE = 28;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [NC-1:0] cnt_up = '0, cnt_dn = '0;
  logic grab_n = 1'b1, show_n = 1'b1, done_n = 1'b1, ovchk_n = 1'b1;
  logic [1:0] wb_top = 2'b00;
  logic [15:0] rbus;
  logic rbus_oe, irq_tmra, irq_tmrb;
  logic [1:0] subseq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ctr_prio_arbiter u0 (
    .clk(clk), .rst(rst), .tick(tick), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .grab_n(grab_n), .show_n(show_n), .done_n(done_n), .ovchk_n(ovchk_n),
    .wb_top(wb_top), .rbus(rbus), .rbus_oe(rbus_oe), .subseq(subseq),
    .irq_tmra(irq_tmra), .irq_tmrb(irq_tmrb)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic          tk;
    logic [NC-1:0] up;
    logic [NC-1:0] dn;
    logic          g, s, d, o;
    logic [1:0]    wb;
    logic [1:0]    xs;
    logic [15:0]   xrb;
    logic          xa, xb;
  } vec_t;

  localparam int NV = 52;
  // wb: 01 positive overflow, 10 negative overflow, 00/11 none
  localparam vec_t TBL [NV] = '{
    '{1, 0,5'b0,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0},   // R1 idle after reset
    '{3, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd0,16'd0, 0,0},   // R3 grab with nothing
    '{2, 1,5'b0,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0},   // R2 tick
    '{3, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},   // R3 low clock word up
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd1,16'd30,0,0},   // R4 addr 036
    '{6, 0,5'b0,5'b0,1,1,0,1,2'b01,2'd0,16'd0, 0,0},   // R6 carry
    '{6, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},   // R6 high word wins
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd1,16'd29,0,0},   // R4
    '{5, 0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},   // R5
    '{3, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},   // R3 timer A
    '{7, 0,5'b0,5'b0,1,1,0,1,2'b01,2'd0,16'd0, 1,0},   // R7 irq A
    '{7, 0,5'b0,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0},   // R7 single pulse
    '{3, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},   // R3 timer B
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd1,16'd32,0,0},   // R4 addr 040
    '{7, 0,5'b0,5'b0,1,1,0,1,2'b01,2'd0,16'd0, 0,1},   // R7 irq B
    '{8, 0,5'b0,5'b0,1,1,1,0,2'b10,2'd0,16'd0, 0,0},   // R8 negative
    '{8, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd2,16'd0, 0,0},   // R8 down select
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd2,16'd28,0,0},   // R4 addr 034
    '{5, 0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},   // R5
    '{9, 0,5'b00010,5'b00010,1,1,1,1,2'b00,2'd0,16'd0,0,0}, // R9 together
    '{9, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd0,16'd0, 0,0},   // R9 nothing left
    '{9, 0,5'b01000,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0},
    '{9, 0,5'b0,5'b01000,1,1,1,1,2'b00,2'd0,16'd0, 0,0}, // R9 successive
    '{9, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd0,16'd0, 0,0},
    '{3, 0,5'b10000,5'b00100,1,1,1,1,2'b00,2'd0,16'd0,0,0},
    '{3, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd2,16'd0, 0,0},   // R3 lower index first
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd2,16'd30,0,0},
    '{5, 0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},
    '{3, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},
    '{5, 0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},
    '{10,0,5'b01000,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0},
    '{10,0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},
    '{10,0,5'b01000,5'b0,1,1,1,1,2'b00,2'd1,16'd0, 0,0}, // R10 arrives in flight
    '{10,0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},
    '{10,0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},   // R10 kept
    '{10,0,5'b0,5'b0,1,0,1,1,2'b00,2'd1,16'd31,0,0},
    '{10,0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},
    '{10,0,5'b10000,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0},
    '{10,0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},
    '{10,0,5'b0,5'b10000,1,1,1,1,2'b00,2'd1,16'd0, 0,0}, // R10 opposite in flight
    '{10,0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},
    '{10,0,5'b0,5'b0,0,1,1,1,2'b00,2'd2,16'd0, 0,0},   // R10 not cancelled
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd2,16'd32,0,0},
    '{5, 0,5'b0,5'b0,1,1,0,1,2'b00,2'd0,16'd0, 0,0},
    '{8, 0,5'b0,5'b0,1,1,1,0,2'b01,2'd0,16'd0, 0,0},   // R8 positive
    '{8, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd1,16'd0, 0,0},
    '{7, 0,5'b0,5'b0,1,1,0,1,2'b01,2'd0,16'd0, 0,0},   // R7 no irq for index 0
    '{8, 0,5'b0,5'b0,1,1,1,0,2'b11,2'd0,16'd0, 0,0},   // R8 no-op code
    '{8, 0,5'b0,5'b0,0,1,1,1,2'b00,2'd0,16'd0, 0,0},
    '{4, 0,5'b0,5'b0,1,0,1,1,2'b00,2'd0,16'd0, 0,0},   // R4 nothing latched
    '{7, 0,5'b0,5'b0,1,1,0,1,2'b01,2'd0,16'd0, 0,0},   // R7 retire w/o selection
    '{7, 0,5'b0,5'b0,1,1,1,1,2'b00,2'd0,16'd0, 0,0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic [NC-1:0] up, dn,
                     input logic g, s, d, o, input logic [1:0] wb);
    @(negedge clk);
    tick = tk; cnt_up = up; cnt_dn = dn;
    grab_n = g; show_n = s; done_n = d; ovchk_n = o; wb_top = wb;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 subseq in reset", int'(subseq), 0);
    chk("R1 irq in reset", int'({irq_tmra, irq_tmrb}), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      cyc(TBL[k].tk, TBL[k].up, TBL[k].dn, TBL[k].g, TBL[k].s, TBL[k].d,
          TBL[k].o, TBL[k].wb);
      chk($sformatf("R%0d v%0d subseq", TBL[k].req, k), int'(subseq), int'(TBL[k].xs));
      chk($sformatf("R%0d v%0d rbus", TBL[k].req, k), int'(rbus), int'(TBL[k].xrb));
      chk($sformatf("R%0d v%0d rbus_oe", TBL[k].req, k), int'(rbus_oe), int'(!TBL[k].s));
      chk($sformatf("R%0d v%0d irq", TBL[k].req, k), int'({irq_tmra, irq_tmrb}),
          int'({TBL[k].xa, TBL[k].xb}));
    end

    // R3: several pending at once drain in address order
    cyc(0, 5'b11110, 5'b0, 1, 1, 1, 1, 2'b00);
    for (int i = 1; i < NC; i++) begin
      cyc(0, 5'b0, 5'b0, 0, 1, 1, 1, 2'b00);
      chk("R3 drain select", int'(subseq), 1);
      cyc(0, 5'b0, 5'b0, 1, 0, 1, 1, 2'b00);
      chk("R3 drain order", int'(rbus), BASE + i);
      cyc(0, 5'b0, 5'b0, 1, 1, 0, 1, 2'b00);
    end

    // R1: reset mid-activity drops latched select and pending cells
    cyc(1, 5'b0, 5'b0, 1, 1, 1, 1, 2'b00);
    cyc(0, 5'b0, 5'b0, 0, 1, 1, 1, 2'b00);
    chk("R1 pre-reset select", int'(subseq), 1);
    @(negedge clk);
    grab_n = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 select after reset", int'(subseq), 0);
    @(negedge clk);
    rst = 1'b0;
    cyc(0, 5'b0, 5'b0, 0, 1, 1, 1, 2'b00);
    chk("R1 cells empty after reset", int'(subseq), 0);
    cyc(0, 5'b0, 5'b0, 1, 1, 1, 1, 2'b00);

    finish_run();
  end

endmodule